// File: doc/BRIEF.md
# Two-Stage Programmable Clock Divider

This block is a leaf of a clock-generation tree. It takes a set of source tick strobes, picks one of them, and divides its rate by a programmable ratio to produce a divided clock level. The ratio is the product of two stages. The pre-divider stage works either as a power-of-two shift or as a plain linear divisor. The linear stage carries a build-time offset. A fixed post-divide parameter and a half-rate timing bit multiply the ratio further.

Software writes one configuration register and can read it back. The register holds the two divisor fields, the pre-divider mode, the half-rate bit, the source select and a gate enable. Changes to the ratio, the source and the gate are deferred to the end of the current output period. This keeps the output free of runt or partial pulses.

All logic runs on one system clock. The selected source is a one-cycle tick enable, and the output is a registered level that advances only on ticks of that source.

Top module: `twostage_clkdiv`

## Requirements
- R1: In shift mode (register bit 6 = 0), the pre-divide factor is 2 to the power of the P field (bits 5:4).
- R2: In linear mode (bit 6 = 1), the pre-divide factor equals the P field. A P field of 0 is taken as 1.
- R3: The linear factor is the M field (bits 3:0) plus the parameter M_OFS. If that sum is 0, it is taken as 1.
- R4: The total ratio is the pre-divide factor, times the linear factor, times the parameter POST_DIV. It is doubled again when the half-rate bit (bit 7) is 1.
- R5: A total ratio below 2 is raised to 2.
- R6: Each output period lasts ratio ticks of the selected source. The output is high for the first floor(ratio/2) ticks of the period and low for the rest, so an odd ratio is high one tick shorter than low.
- R7: A register write changes the ratio, the gate and the source only at the tick that ends the current period. The period in progress completes with its old settings.
- R8: The gate enable (bit 15) is sampled only at a period boundary. While the gate is off the output stays low, and it only ever rises at the start of a period.
- R9: Only ticks of the source chosen by the select field (bits 9:8) advance the divider. Ticks of every other source have no effect.
- R10: rd_data returns the last written register value. After reset, rd_data is 0, clk_out is low, and the first period is 2 ticks long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_tick | input | NSRC | One-cycle tick strobes, one per source |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | REG_W | Register write value |
| rd_data | output | REG_W | Register readback |
| clk_out | output | 1 | Divided clock level |

## Verification
A wrong live ratio, a wrong high count or a counter that misses a wrap shows up on clk_out within one output period, as an edge in the wrong cycle. The worst case is well under a thousand system cycles with the default widths. If a deferred setting were applied too early, the edge in error would appear in the very period that the write interrupts. A wrong source index makes the edge spacing follow the wrong tick pattern from the next boundary on. A register fault appears on rd_data in the cycle after the write.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;

  // Total divide ratio from the register fields and build parameters.
  function automatic int unsigned calc_ratio(
    input int unsigned m_fld,
    input int unsigned p_fld,
    input bit          linear_p,
    input bit          half_rate,
    input int unsigned m_ofs,
    input int unsigned post_div
  );
    int unsigned pre;
    int unsigned lin;
    int unsigned r;
    if (linear_p) pre = (p_fld == 0) ? 1 : p_fld;
    else          pre = 32'd1 << p_fld;
    lin = m_fld + m_ofs;
    if (lin == 0) lin = 1;
    r = pre * lin * post_div;
    if (half_rate) r = r * 2;
    if (r < 2) r = 2;
    return r;
  endfunction

endpackage

// File: rtl/cdiv_cfg_reg.sv
module cdiv_cfg_reg #(
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] cfg_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cfg_q <= '0;
    else if (wr_en) cfg_q <= wr_data;
  end

endmodule

// File: rtl/cdiv_ratio.sv
module cdiv_ratio #(
  parameter int M_W      = 4,
  parameter int P_W      = 2,
  parameter int CNT_W    = 16,
  parameter int M_OFS    = 0,
  parameter int POST_DIV = 1
) (
  input  logic [M_W-1:0]   m_fld,
  input  logic [P_W-1:0]   p_fld,
  input  logic             linear_p,
  input  logic             half_rate,
  output logic [CNT_W-1:0] ratio,
  output logic [CNT_W-1:0] high_len
);
  import cdiv_pkg::*;

  int unsigned r_full;

  always_comb begin
    r_full   = calc_ratio(32'(m_fld), 32'(p_fld), linear_p, half_rate,
                          32'(M_OFS), 32'(POST_DIV));
    ratio    = CNT_W'(r_full);
    high_len = CNT_W'(r_full >> 1);
  end

endmodule

// File: rtl/cdiv_engine.sv
module cdiv_engine #(
  parameter int NSRC  = 4,
  parameter int SEL_W = 2,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src_tick,
  input  logic [CNT_W-1:0] cfg_ratio,
  input  logic [CNT_W-1:0] cfg_high,
  input  logic             cfg_gate,
  input  logic [SEL_W-1:0] cfg_sel,
  output logic             clk_out
);

  logic [CNT_W-1:0] cnt_q, ratio_q, high_q;
  logic [CNT_W-1:0] cnt_n, ratio_n, high_n;
  logic             gate_q, gate_n, out_q;
  logic [SEL_W-1:0] sel_q, sel_n;

  // named events for the assertions
  logic tick_ev;
  logic wrap_ev;

  assign tick_ev = src_tick[sel_q];
  assign wrap_ev = tick_ev && (cnt_q == ratio_q - 1'b1);

  always_comb begin
    cnt_n   = cnt_q;
    ratio_n = ratio_q;
    high_n  = high_q;
    gate_n  = gate_q;
    sel_n   = sel_q;
    if (wrap_ev) begin
      cnt_n   = '0;
      ratio_n = cfg_ratio;
      high_n  = cfg_high;
      gate_n  = cfg_gate;
      sel_n   = cfg_sel;
    end else if (tick_ev) begin
      cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      ratio_q <= CNT_W'(2);
      high_q  <= CNT_W'(1);
      gate_q  <= 1'b0;
      sel_q   <= '0;
      out_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_n;
      ratio_q <= ratio_n;
      high_q  <= high_n;
      gate_q  <= gate_n;
      sel_q   <= sel_n;
      out_q   <= gate_n && (cnt_n < high_n);
    end
  end

  assign clk_out = out_q;

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < ratio_q); // R6
  AST_RATIO_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_q >= CNT_W'(2)); // R5
  AST_HOLD_MIDPERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap_ev |=> $stable(ratio_q) && $stable(gate_q) && $stable(sel_q)); // R7
  AST_RISE_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_out) |-> cnt_q == '0); // R8
  AST_FALL_AT_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_out) |-> cnt_q == high_q); // R6
  AST_IDLE_NO_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_ev |=> $stable(cnt_q)); // R9

endmodule

// File: rtl/twostage_clkdiv.sv
module twostage_clkdiv #(
  parameter int NSRC     = 4,
  parameter int M_W      = 4,
  parameter int P_W      = 2,
  parameter int M_OFS    = 0,
  parameter int POST_DIV = 1,
  parameter int CNT_W    = 16,
  parameter int REG_W    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src_tick,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             clk_out
);

  localparam int SEL_W    = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam int M_LSB    = 0;
  localparam int P_LSB    = M_LSB + M_W;
  localparam int LIN_BIT  = P_LSB + P_W;
  localparam int HALF_BIT = LIN_BIT + 1;
  localparam int SEL_LSB  = HALF_BIT + 1;
  localparam int GATE_BIT = REG_W - 1;

  logic [REG_W-1:0] cfg_q;
  logic [CNT_W-1:0] ratio_w, high_w;

  cdiv_cfg_reg #(.REG_W(REG_W)) u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .cfg_q(cfg_q)
  );

  cdiv_ratio #(
    .M_W(M_W), .P_W(P_W), .CNT_W(CNT_W), .M_OFS(M_OFS), .POST_DIV(POST_DIV)
  ) u_ratio (
    .m_fld    (cfg_q[M_LSB +: M_W]),
    .p_fld    (cfg_q[P_LSB +: P_W]),
    .linear_p (cfg_q[LIN_BIT]),
    .half_rate(cfg_q[HALF_BIT]),
    .ratio    (ratio_w),
    .high_len (high_w)
  );

  cdiv_engine #(.NSRC(NSRC), .SEL_W(SEL_W), .CNT_W(CNT_W)) u_eng (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_tick (src_tick),
    .cfg_ratio(ratio_w),
    .cfg_high (high_w),
    .cfg_gate (cfg_q[GATE_BIT]),
    .cfg_sel  (cfg_q[SEL_LSB +: SEL_W]),
    .clk_out  (clk_out)
  );

  assign rd_data = cfg_q;

  AST_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data == $past(wr_data)); // R10

endmodule

// File: tb/sim_twostage_clkdiv.sv
module sim_twostage_clkdiv;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  src_tick = '0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        clk_out;

  always #2.5 clk = ~clk;

  twostage_clkdiv u0 (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .clk_out(clk_out)
  );

  int    checks = 0;
  int    errors = 0;
  string tag = "R10";
  bit    done = 1'b0;

  // reference model state
  int        m_cnt = 0, m_len = 2, m_hi = 1, m_sel = 0;
  bit        m_gate = 0, m_out = 0;
  bit [15:0] m_reg = '0;

  function automatic int ref_len(bit [15:0] v);
    int pre, lin, t;
    if (v[6]) pre = (v[5:4] == 0) ? 1 : int'(v[5:4]);
    else begin
      pre = 1;
      for (int k = 0; k < int'(v[5:4]); k++) pre = pre * 2;
    end
    lin = int'(v[3:0]);
    if (lin == 0) lin = 1;
    t = pre * lin;
    if (v[7]) t = t + t;
    return (t < 2) ? 2 : t;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_len = 2; m_hi = 1; m_sel = 0; m_gate = 0; m_out = 0; m_reg = '0;
    end else begin
      if (src_tick[m_sel]) begin
        if (m_cnt == m_len - 1) begin
          m_cnt  = 0;
          m_len  = ref_len(m_reg);
          m_hi   = m_len / 2;
          m_gate = m_reg[15];
          m_sel  = int'(m_reg[9:8]);
        end else m_cnt = m_cnt + 1;
      end
      m_out = m_gate && (m_cnt < m_hi);
      if (wr_en) m_reg = wr_data;
    end
  end

  // tick sources: 0 every cycle, 1 every third, 2 pseudo-random, 3 every fifth
  int       cyc = 0;
  bit [7:0] lfsr = 8'hA5;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (clk_out !== m_out) begin
        errors++;
        $display("FAIL %s clk_out actual %0b expected %0b at cycle %0d", tag, clk_out, m_out, cyc);
      end
      checks++;
      if (rd_data !== m_reg) begin
        errors++;
        $display("FAIL %s rd_data actual %h expected %h", tag, rd_data, m_reg);
      end
    end
    cyc++;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    src_tick = {(cyc % 5 == 0), lfsr[0], (cyc % 3 == 0), 1'b1};
  end

  task automatic wr(input bit [15:0] v);
    wr_en = 1'b1; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired (R10 run) actual hung expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (rd_data !== 16'h0 || clk_out !== 1'b0) begin
      errors++;
      $display("FAIL R10 reset actual %h/%0b expected 0000/0", rd_data, clk_out);
    end
    rst_n = 1'b1;
    tag = "R10"; run(10);
    tag = "R1";  wr(16'h8012); run(60);           // shift p=1 m=2 -> 4
    tag = "R1";  wr(16'h8031); run(80);           // shift p=3 m=1 -> 8
    tag = "R6";  wr(16'h8074); run(90);           // linear p=3 m=4 -> 12
    tag = "R2";  wr(16'h8043); run(40);           // linear p=0 m=3 -> 3, odd
    tag = "R3";  wr(16'h8020); run(40);           // shift p=2 m=0 -> 4
    tag = "R5";  wr(16'h8040); run(30);           // linear p=0 m=0 -> clamp 2
    tag = "R4";  wr(16'h8093); run(80);           // half, p=1 m=3 -> 12
    tag = "R7";  run(3); wr(16'h8005); run(2); wr(16'h8062); run(60);
    tag = "R8";  wr(16'h0012); run(40); wr(16'h8012); run(40);
    tag = "R9";  wr(16'h8113); run(150);          // source 1
    tag = "R9";  wr(16'h8212); run(150);          // source 2
    tag = "R9";  wr(16'h8313); run(200);          // source 3
    tag = "R8";  run(1); wr(16'h0313); run(120);
    finish_run();
  end

endmodule